// File: doc/BRIEF.md
# Instruction cache line-fill controller

This block services instruction-cache misses. When a fetch misses both the cache array and the line being filled, the block issues one burst read for the whole line, starting at the line-aligned address. Each returning beat is stored in a one-line burst buffer. A beat that carries the word the core is waiting for is forwarded to the core in the same cycle it arrives. Later fetches that fall inside the line being filled are served from the buffer once their word is present, or straight off the bus on the beat that brings it. They stall while the word is still on its way.

When the burst ends, the block decides what to do with the line. A cacheable line with no errored beat is written into the cache array in one wide write, in the first cycle the array is not busy serving the core. Any errored beat throws the line away. An error on the beat that carries the requested word also raises a machine-check to the core. Lines from non-cacheable pages are never written to the array, and each of their buffered words can be handed out only once; a second fetch of the same address goes back to the bus.

Fetches on a predicted path are served at once when they hit. A predicted-path miss waits until the core strobes that the branch is resolved. It is dropped with no bus traffic if the core cancels the path first. Only one burst is in flight at a time.

Top module: `icache_fill_ctrl`

## Requirements
- R1: On a miss, the requested word is driven on `ins_data` with `ins_valid` high in the same cycle its beat is on the bus (`bus_rvalid` high, `bus_err` low).
- R2: A held fetch to a word of the line being filled is served from the bus on that word's beat, or from the buffer once the word has arrived. Until the word arrives, `ins_valid` stays low and no new `bus_req` is raised.
- R3: `arr_we` is raised only in a cycle where `arr_busy` is low, and for a single cycle per committed line.
- R4: A bus error on the beat that carries the requested word pulses `mchk` in that cycle with `ins_valid` low, and the line is never written to the array.
- R5: A bus error on any other beat raises no `mchk`. The line is never written to the array, and no later fetch is served from that buffer, not even for words that arrived before the error.
- R6: A cacheable line whose four beats are all error-free is written once to the array. `arr_addr` is the line-aligned address, and `arr_line` holds word k (byte address offset 4*k) at bits [32k+31:32k].
- R7: For a line fetched with `fetch_cacheable` low, `arr_we` never rises. Each word is delivered at most once, whether it came from the bus or from the buffer. A repeated fetch of a delivered word raises a new `bus_req`.
- R8: A fetch with `fetch_spec` high that hits the array (`array_hit`) is served at once. If it misses, `bus_req` stays low until a cycle where `spec_resolve` is high or has been high during the same request.
- R9: When `spec_cancel` is high, no `bus_req` is raised in that cycle. A resolve strobe seen before or with the cancel does not carry over to a later request.
- R10: While a burst is in flight, or its line is waiting to be committed, no new `bus_req` is raised. A waiting miss launches in the cycle after the commit.
- R11: `bus_req` is a single-cycle pulse whose `bus_addr` is the line-aligned fetch address (bits [3:0] zero). Beats return in word order 0 to 3, where the word index is address bits [3:2].
- R12: After reset, and whenever `fetch_req` is low, `ins_valid` is low. Out of reset, `bus_req`, `arr_we` and `mchk` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Core fetch request, held until served or dropped |
| fetch_addr | input | ADDR_W | Byte address of the fetch |
| fetch_spec | input | 1 | Fetch lies on a predicted path |
| spec_resolve | input | 1 | Branch resolved strobe |
| spec_cancel | input | 1 | Predicted path cancelled |
| fetch_cacheable | input | 1 | Page of the fetch is cacheable |
| array_hit | input | 1 | Cache array hit for the current fetch |
| array_rdata | input | DATA_W | Word read from the cache array |
| ins_valid | output | 1 | Instruction word delivered this cycle |
| ins_data | output | DATA_W | Delivered instruction word |
| mchk | output | 1 | Machine-check indication |
| bus_req | output | 1 | Start a line burst read |
| bus_addr | output | ADDR_W | Line-aligned burst address |
| bus_rvalid | input | 1 | Burst beat present |
| bus_rdata | input | DATA_W | Burst beat data |
| bus_err | input | 1 | Burst beat returned an error |
| arr_busy | input | 1 | Array is serving a core access |
| arr_we | output | 1 | Write the buffered line to the array |
| arr_addr | output | ADDR_W | Line-aligned address of the write |
| arr_line | output | DATA_W*LINE_WORDS | Line data, word 0 in the low bits |

## Verification
The bench fires a miss in the middle of a line and then asks for the word after it before that beat has come in. A controller that served stale buffer contents there, or that launched a second burst, would be caught. It puts the bus error on the critical beat in one test and on a non-critical beat in another. Mixing them up shows as a missing or spurious machine-check, or as a poisoned line still being committed or still hitting. Non-cacheable lines are fetched twice from the same address: a design that keeps those words valid serves the second fetch instead of going back to the bus. Predicted-path misses are checked around the resolve and cancel strobes, including both in one cycle and a resolve that arrives with no request. A second miss is held over the busy-array commit to show that it launches only after the line has been written.

// File: rtl/icf_pkg.sv
package icf_pkg;

   // Sequencer states of the line fill
   typedef enum logic [1:0] {
      FS_IDLE   = 2'd0,
      FS_FILL   = 2'd1,
      FS_COMMIT = 2'd2
   } fill_st_t;

endpackage

// File: rtl/icf_spec_gate.sv
// Holds back a miss on a predicted path until the branch resolves.
module icf_spec_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic fetch_req,
   input  logic fetch_spec,
   input  logic spec_resolve,
   input  logic spec_cancel,
   input  logic served,
   output logic go_ok
);

   logic resolved_q;

   assign go_ok = !spec_cancel && (!fetch_spec || resolved_q || spec_resolve);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resolved_q <= 1'b0;
      end else begin
         resolved_q <= fetch_req && fetch_spec && !spec_cancel && !served &&
                       (resolved_q || spec_resolve);
      end
   end

endmodule

// File: rtl/icf_fill_seq.sv
// Burst sequencer: counts beats, tracks errors and makes the commit decision.
module icf_fill_seq
   import icf_pkg::*;
#(
   parameter int LINE_WORDS = 4,
   localparam int IDX_W = $clog2(LINE_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic [IDX_W-1:0] launch_word,
   input  logic             launch_cach,
   input  logic             bus_rvalid,
   input  logic             bus_err,
   input  logic             arr_busy,
   output fill_st_t         st,
   output logic [IDX_W-1:0] beat_idx,
   output logic             line_cach,
   output logic             beat_wr,
   output logic             crit_err,
   output logic             commit_we
);

   localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(LINE_WORDS - 1);

   logic [IDX_W-1:0] crit_q;
   logic             bad_q;

   assign beat_wr   = (st == FS_FILL) && bus_rvalid;
   assign crit_err  = beat_wr && bus_err && (beat_idx == crit_q);
   assign commit_we = (st == FS_COMMIT) && !arr_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= FS_IDLE;
         beat_idx  <= '0;
         crit_q    <= '0;
         bad_q     <= 1'b0;
         line_cach <= 1'b0;
      end else begin
         unique case (st)
            FS_IDLE: begin
               if (launch) begin
                  st        <= FS_FILL;
                  beat_idx  <= '0;
                  crit_q    <= launch_word;
                  bad_q     <= 1'b0;
                  line_cach <= launch_cach;
               end
            end
            FS_FILL: begin
               if (bus_rvalid) begin
                  beat_idx <= IDX_W'(beat_idx + 1'b1);
                  bad_q    <= bad_q || bus_err;
                  if (beat_idx == LAST_BEAT) begin
                     st <= (line_cach && !bad_q && !bus_err) ? FS_COMMIT : FS_IDLE;
                  end
               end
            end
            FS_COMMIT: begin
               if (!arr_busy) st <= FS_IDLE;
            end
            default: st <= FS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/icf_burst_buf.sv
// One-line burst buffer with a valid bit per word.
module icf_burst_buf #(
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int TAG_W      = 28,
   localparam int IDX_W  = $clog2(LINE_WORDS),
   localparam int LINE_W = DATA_W * LINE_WORDS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  launch,
   input  logic [TAG_W-1:0]      launch_tag,
   input  logic                  wr_en,
   input  logic                  wr_err,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  wr_keep,
   input  logic [IDX_W-1:0]      rd_idx,
   input  logic                  rd_clear,
   output logic [TAG_W-1:0]      buf_tag,
   output logic                  buf_ok,
   output logic [LINE_WORDS-1:0] word_vld,
   output logic [DATA_W-1:0]     rd_data,
   output logic [LINE_W-1:0]     line_data
);

   logic [DATA_W-1:0] words [LINE_WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_tag <= '0;
         buf_ok  <= 1'b0;
      end else if (launch) begin
         buf_tag <= launch_tag;
         buf_ok  <= 1'b1;
      end else if (wr_en && wr_err) begin
         buf_ok  <= 1'b0;
      end
   end

   for (genvar i = 0; i < LINE_WORDS; i++) begin : g_word
      logic hit_wr;
      assign hit_wr = wr_en && !wr_err && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_vld[i] <= 1'b0;
            words[i]    <= '0;
         end else if (launch) begin
            word_vld[i] <= 1'b0;
         end else if (hit_wr) begin
            word_vld[i] <= wr_keep;
            words[i]    <= wr_data;
         end else if (rd_clear && (rd_idx == IDX_W'(i))) begin
            word_vld[i] <= 1'b0;
         end
      end

      assign line_data[i*DATA_W +: DATA_W] = words[i];
   end

   assign rd_data = words[rd_idx];

endmodule

// File: rtl/icache_fill_ctrl.sv
// Instruction-cache line-fill controller (top).
module icache_fill_ctrl
   import icf_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4,
   localparam int BYTE_OFF = $clog2(DATA_W / 8),
   localparam int IDX_W    = $clog2(LINE_WORDS),
   localparam int TAG_LSB  = BYTE_OFF + IDX_W,
   localparam int TAG_W    = ADDR_W - TAG_LSB,
   localparam int LINE_W   = DATA_W * LINE_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_spec,
   input  logic              spec_resolve,
   input  logic              spec_cancel,
   input  logic              fetch_cacheable,
   input  logic              array_hit,
   input  logic [DATA_W-1:0] array_rdata,
   output logic              ins_valid,
   output logic [DATA_W-1:0] ins_data,
   output logic              mchk,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rvalid,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_err,
   input  logic              arr_busy,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [LINE_W-1:0] arr_line
);

   // Elaboration-time parameter checks
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_words
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("DATA_W must be a power of two of at least 8");
   end
   if (ADDR_W <= TAG_LSB) begin : g_bad_addr
      $error("ADDR_W too small for the line size");
   end

   logic [TAG_W-1:0]      req_tag;
   logic [IDX_W-1:0]      req_word;
   logic                  unused_low;
   fill_st_t              st;
   logic [IDX_W-1:0]      beat_idx;
   logic                  line_cach, beat_wr, crit_err, commit_we;
   logic [TAG_W-1:0]      buf_tag;
   logic                  buf_ok;
   logic [LINE_WORDS-1:0] word_vld;
   logic [DATA_W-1:0]     buf_rdata;
   logic                  go_ok, filling, buf_match, not_yet;
   logic                  byp_hit, buf_hit, miss, launch;

   assign req_tag    = fetch_addr[ADDR_W-1:TAG_LSB];
   assign req_word   = fetch_addr[TAG_LSB-1:BYTE_OFF];
   assign unused_low = ^fetch_addr[BYTE_OFF-1:0];

   assign filling   = (st == FS_FILL);
   assign buf_match = buf_ok && (buf_tag == req_tag);
   assign not_yet   = filling && (req_word >= beat_idx);
   assign byp_hit   = fetch_req && !array_hit && buf_match && beat_wr && !bus_err &&
                      (beat_idx == req_word);
   assign buf_hit   = fetch_req && !array_hit && buf_match && word_vld[req_word];
   assign miss      = fetch_req && !array_hit && !byp_hit && !buf_hit &&
                      !(buf_match && not_yet);
   assign launch    = miss && go_ok && (st == FS_IDLE);

   icf_spec_gate u_spec (
      .clk          (clk),
      .rst_n        (rst_n),
      .fetch_req    (fetch_req),
      .fetch_spec   (fetch_spec),
      .spec_resolve (spec_resolve),
      .spec_cancel  (spec_cancel),
      .served       (ins_valid || mchk || launch),
      .go_ok        (go_ok)
   );

   icf_fill_seq #(.LINE_WORDS(LINE_WORDS)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch      (launch),
      .launch_word (req_word),
      .launch_cach (fetch_cacheable),
      .bus_rvalid  (bus_rvalid),
      .bus_err     (bus_err),
      .arr_busy    (arr_busy),
      .st          (st),
      .beat_idx    (beat_idx),
      .line_cach   (line_cach),
      .beat_wr     (beat_wr),
      .crit_err    (crit_err),
      .commit_we   (commit_we)
   );

   icf_burst_buf #(
      .DATA_W     (DATA_W),
      .LINE_WORDS (LINE_WORDS),
      .TAG_W      (TAG_W)
   ) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .launch_tag (req_tag),
      .wr_en      (beat_wr),
      .wr_err     (bus_err),
      .wr_idx     (beat_idx),
      .wr_data    (bus_rdata),
      .wr_keep    (line_cach || !byp_hit),
      .rd_idx     (req_word),
      .rd_clear   (buf_hit && !line_cach),
      .buf_tag    (buf_tag),
      .buf_ok     (buf_ok),
      .word_vld   (word_vld),
      .rd_data    (buf_rdata),
      .line_data  (arr_line)
   );

   assign ins_valid = fetch_req && (array_hit || buf_hit || byp_hit);
   assign ins_data  = array_hit ? array_rdata : (byp_hit ? bus_rdata : buf_rdata);
   assign mchk      = crit_err;
   assign bus_req   = launch;
   assign bus_addr  = {req_tag, {TAG_LSB{1'b0}}};
   assign arr_we    = commit_we;
   assign arr_addr  = {buf_tag, {TAG_LSB{1'b0}}};

endmodule

// File: rtl/icf_fill_ctrl_chk.sv
// Protocol checker bound to the fill controller.
module icf_fill_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic fetch_req,
   input logic fetch_spec,
   input logic spec_resolve,
   input logic spec_cancel,
   input logic ins_valid,
   input logic mchk,
   input logic bus_req,
   input logic bus_rvalid,
   input logic bus_err,
   input logic arr_busy,
   input logic arr_we
);

   // Tracks a resolve strobe seen during the current predicted-path request
   logic seen_res;
   always_ff @(posedge clk) begin
      if (!rst_n) seen_res <= 1'b0;
      else        seen_res <= fetch_req && !spec_cancel && !ins_valid && !mchk &&
                              !bus_req && (seen_res || spec_resolve);
   end

   // R3
   commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> !arr_busy);

   // R3
   commit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |=> !arr_we);

   // R4
   mchk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mchk |-> (bus_rvalid && bus_err && !ins_valid));

   // R8
   spec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && fetch_spec) |-> (spec_resolve || seen_res));

   // R9
   cancel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spec_cancel |-> !bus_req);

   // R11
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> !bus_req);

   // R12
   deliver_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid |-> fetch_req);

endmodule

bind icache_fill_ctrl icf_fill_ctrl_chk u_chk (.*);

// File: tb/icache_fill_ctrl_bench.sv
module icache_fill_ctrl_bench;

   localparam int AW = 32;
   localparam int DW = 32;
   localparam int LW = 128;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          fetch_req, fetch_spec, spec_resolve, spec_cancel, fetch_cacheable;
   logic [AW-1:0] fetch_addr;
   logic          array_hit;
   logic [DW-1:0] array_rdata;
   logic          ins_valid, mchk, bus_req, arr_we;
   logic [DW-1:0] ins_data;
   logic [AW-1:0] bus_addr, arr_addr;
   logic          bus_rvalid, bus_err, arr_busy;
   logic [DW-1:0] bus_rdata;
   logic [LW-1:0] arr_line;

   int nchk = 0;
   int nerr = 0;

   always #2 clk = ~clk;

   icache_fill_ctrl u_icache_fill_ctrl (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_spec(fetch_spec), .spec_resolve(spec_resolve), .spec_cancel(spec_cancel),
      .fetch_cacheable(fetch_cacheable), .array_hit(array_hit), .array_rdata(array_rdata),
      .ins_valid(ins_valid), .ins_data(ins_data), .mchk(mchk), .bus_req(bus_req),
      .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .arr_busy(arr_busy), .arr_we(arr_we), .arr_addr(arr_addr),
      .arr_line(arr_line)
   );

   function automatic logic [DW-1:0] bdat(input logic [AW-1:0] a);
      return 32'h5A00_0000 ^ a;
   endfunction

   task automatic chk(input string rq, input logic [LW-1:0] act, input logic [LW-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic smp();
      #1;
   endtask

   task automatic beat(input logic [AW-1:0] base, input int b, input logic e);
      bus_rvalid = 1'b1;
      bus_rdata  = bdat(base + AW'(b * 4));
      bus_err    = e;
   endtask

   task automatic no_beat();
      bus_rvalid = 1'b0;
      bus_rdata  = '0;
      bus_err    = 1'b0;
   endtask

   // Completes a launched burst with no errors and lets any commit drain
   task automatic run_burst(input logic [AW-1:0] base);
      for (int b = 0; b < 4; b++) begin
         step();
         fetch_req = 1'b0;
         beat(base, b, 1'b0);
      end
      step(); no_beat();
      step(); step();
   endtask

   task automatic t_reset();
      step(); smp();
      chk("R12 ins_valid", ins_valid, 0);
      chk("R12 bus_req", bus_req, 0);
      chk("R12 arr_we", arr_we, 0);
      chk("R12 mchk", mchk, 0);
   endtask

   task automatic t_fill_commit();
      step(); fetch_req = 1; fetch_addr = 32'h108; fetch_cacheable = 1; smp();
      chk("R11 bus_req", bus_req, 1);
      chk("R11 bus_addr", bus_addr, 32'h100);
      step(); smp();
      chk("R11 single pulse", bus_req, 0);
      step(); beat(32'h100, 0, 0); smp();
      chk("R2 stall before word", ins_valid, 0);
      step(); beat(32'h100, 1, 0);
      step(); beat(32'h100, 2, 0); smp();
      chk("R1 crit valid", ins_valid, 1);
      chk("R1 crit data", ins_data, bdat(32'h108));
      step(); no_beat(); fetch_addr = 32'h10C; smp();
      chk("R2 stall next word", ins_valid, 0);
      chk("R2 no relaunch", bus_req, 0);
      step(); beat(32'h100, 3, 0); smp();
      chk("R2 bus stream valid", ins_valid, 1);
      chk("R2 bus stream data", ins_data, bdat(32'h10C));
      step(); no_beat(); fetch_addr = 32'h100; arr_busy = 1; smp();
      chk("R2 buffer hit valid", ins_valid, 1);
      chk("R2 buffer hit data", ins_data, bdat(32'h100));
      chk("R3 no write while busy", arr_we, 0);
      step(); fetch_req = 0; smp();
      chk("R3 still busy", arr_we, 0);
      step(); arr_busy = 0; smp();
      chk("R6 commit", arr_we, 1);
      chk("R6 commit addr", arr_addr, 32'h100);
      chk("R6 commit line", arr_line,
          {bdat(32'h10C), bdat(32'h108), bdat(32'h104), bdat(32'h100)});
      step(); smp();
      chk("R3 single write", arr_we, 0);
   endtask

   task automatic t_crit_err();
      step(); fetch_req = 1; fetch_addr = 32'h204; fetch_cacheable = 1; smp();
      chk("R11 launch", bus_req, 1);
      step(); beat(32'h200, 0, 0);
      step(); beat(32'h200, 1, 1); smp();
      chk("R4 mchk", mchk, 1);
      chk("R4 no delivery", ins_valid, 0);
      step(); fetch_req = 0; beat(32'h200, 2, 0); smp();
      chk("R4 mchk one beat", mchk, 0);
      step(); beat(32'h200, 3, 0);
      step(); no_beat(); smp();
      chk("R4 no commit", arr_we, 0);
      step(); smp();
      chk("R4 no commit later", arr_we, 0);
      step(); fetch_req = 1; fetch_addr = 32'h200; smp();
      chk("R5 buffer dropped valid", ins_valid, 0);
      chk("R5 buffer dropped refetch", bus_req, 1);
      run_burst(32'h200);
   endtask

   task automatic t_other_err();
      step(); fetch_req = 1; fetch_addr = 32'h300; fetch_cacheable = 1; smp();
      chk("R11 launch", bus_req, 1);
      step(); beat(32'h300, 0, 0); smp();
      chk("R1 word0 valid", ins_valid, 1);
      chk("R1 word0 data", ins_data, bdat(32'h300));
      step(); fetch_req = 0; beat(32'h300, 1, 0);
      step(); beat(32'h300, 2, 1); smp();
      chk("R5 no mchk", mchk, 0);
      step(); beat(32'h300, 3, 0);
      step(); no_beat(); smp();
      chk("R5 no commit", arr_we, 0);
      step(); fetch_req = 1; fetch_addr = 32'h304; smp();
      chk("R5 no buffer hit", ins_valid, 0);
      chk("R5 refetch", bus_req, 1);
      run_burst(32'h300);
   endtask

   task automatic t_noncache();
      step(); fetch_req = 1; fetch_addr = 32'h400; fetch_cacheable = 0; smp();
      chk("R11 launch", bus_req, 1);
      step(); beat(32'h400, 0, 0); smp();
      chk("R7 bypass", ins_valid, 1);
      step(); beat(32'h400, 1, 0); smp();
      chk("R7 bypass used once", ins_valid, 0);
      step(); fetch_req = 0; beat(32'h400, 2, 0);
      step(); beat(32'h400, 3, 0);
      step(); no_beat(); smp();
      chk("R7 no commit", arr_we, 0);
      step(); smp();
      chk("R7 no commit later", arr_we, 0);
      step(); fetch_req = 1; fetch_addr = 32'h404; smp();
      chk("R7 first buffer use", ins_valid, 1);
      chk("R7 first buffer data", ins_data, bdat(32'h404));
      step(); smp();
      chk("R7 second use refused", ins_valid, 0);
      chk("R7 second use refetch", bus_req, 1);
      run_burst(32'h400);
      fetch_cacheable = 1;
   endtask

   task automatic t_spec();
      step(); fetch_req = 1; fetch_addr = 32'h500; fetch_spec = 1;
      array_hit = 1; array_rdata = 32'h1234_ABCD; smp();
      chk("R8 spec hit valid", ins_valid, 1);
      chk("R8 spec hit data", ins_data, 32'h1234_ABCD);
      step(); array_hit = 0; smp();
      chk("R8 spec miss held", bus_req, 0);
      step(); smp();
      chk("R8 spec miss still held", bus_req, 0);
      step(); spec_resolve = 1; smp();
      chk("R8 launch on resolve", bus_req, 1);
      chk("R8 launch addr", bus_addr, 32'h500);
      step(); spec_resolve = 0; fetch_spec = 0; fetch_req = 0;
      run_burst(32'h500);
   endtask

   task automatic t_cancel();
      step(); fetch_req = 1; fetch_addr = 32'h600; fetch_spec = 1; smp();
      chk("R9 pending", bus_req, 0);
      step(); spec_cancel = 1; smp();
      chk("R9 cancel quiet", bus_req, 0);
      step(); spec_cancel = 0; fetch_req = 0; spec_resolve = 1; smp();
      chk("R9 stray resolve", bus_req, 0);
      step(); spec_resolve = 0; fetch_req = 1; smp();
      chk("R9 no carried resolve", bus_req, 0);
      step(); spec_resolve = 1; spec_cancel = 1; smp();
      chk("R9 cancel beats resolve", bus_req, 0);
      step(); spec_resolve = 0; spec_cancel = 0; smp();
      chk("R9 resolve not kept", bus_req, 0);
      step(); fetch_req = 0; fetch_spec = 0;
   endtask

   task automatic t_one_out();
      step(); fetch_req = 1; fetch_addr = 32'h700; fetch_cacheable = 1; arr_busy = 1; smp();
      chk("R11 launch", bus_req, 1);
      step(); fetch_addr = 32'h800; smp();
      chk("R10 blocked in fill", bus_req, 0);
      for (int b = 0; b < 4; b++) begin
         step(); beat(32'h700, b, 0);
      end
      step(); no_beat(); smp();
      chk("R10 blocked in commit", bus_req, 0);
      chk("R3 busy hold", arr_we, 0);
      step(); arr_busy = 0; smp();
      chk("R10 commit first", arr_we, 1);
      chk("R10 not yet", bus_req, 0);
      step(); smp();
      chk("R10 launch after commit", bus_req, 1);
      chk("R10 launch addr", bus_addr, 32'h800);
      step(); fetch_req = 0;
      run_burst(32'h800);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      rst_n = 0; fetch_req = 0; fetch_addr = '0; fetch_spec = 0; spec_resolve = 0;
      spec_cancel = 0; fetch_cacheable = 1; array_hit = 0; array_rdata = '0;
      bus_rvalid = 0; bus_rdata = '0; bus_err = 0; arr_busy = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_fill_commit();
      t_crit_err();
      t_other_err();
      t_noncache();
      t_spec();
      t_cancel();
      t_one_out();
      summary();
   end

   initial begin
      #(200000 * 4);
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

endmodule